// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor

This block sits in the front end of a processor and decides, in the same cycle as a fetch lookup, whether a branch will be taken and where it will go. Each lookup presents the branch PC, a three-bit kind code, a flag that says whether the decoded target lies below the PC, the decoded static target, and the fall-through address. The block answers with a prediction-valid flag, a taken bit, a predicted target and a two-bit code naming the source of the prediction.

Dynamic predictions come from a direct-mapped, tagged target buffer. Each entry holds a valid bit, a partial PC tag, a target and a two-bit saturating counter. The buffer changes only when a retired branch reports its resolved outcome through the update port. A lookup that misses in the buffer falls back to a fixed rule: a backward branch is taken and a forward branch is not. Returns take their targets from a circular return stack, which calls push and returns pop. Far transfers get no prediction.

Top module: `branch_pred`

## Requirements
- R1: Far kinds (kind 4 far call, 5 interrupt return, 6 software interrupt, 7 reserved) give pr_valid=0, pr_taken=0, pr_src=0, and leave the return stack unchanged.
- R2: A conditional branch (kind 0) that misses the buffer is predicted taken when lk_backward=1 and not taken when lk_backward=0. The target is lk_static_tgt and pr_src=2 (static).
- R3: A lookup never writes the buffer. Repeating a lookup that misses still gives the static result.
- R4: A retirement update that misses the buffer allocates the entry with counter 2 if taken and 1 if not taken, and stores upd_target. A later conditional lookup then follows the counter with pr_src=1 (buffer), even when that contradicts the static rule.
- R5: Each update that hits moves the counter one step toward its outcome, saturating at 0 and 3. A conditional hit predicts taken exactly when the counter is 2 or 3.
- R6: The buffer is indexed by pc[5:2] and tagged by pc[13:6]. A PC with the same index and a different tag misses.
- R7: A direct call (kind 1) is predicted taken. Its target is the buffer target on a hit and lk_static_tgt on a miss. It pushes lk_fallthru onto the return stack.
- R8: A return (kind 2) on a non-empty stack is predicted taken to the most recently pushed address still on the stack, with pr_src=3 (stack), and it pops that address.
- R9: A return on an empty stack gives pr_valid=0, pr_src=0.
- R10: The return stack holds 16 entries. A push into a full stack overwrites the oldest entry, so after 17 pushes, 16 returns give the 16 newest addresses and the 17th return finds the stack empty.
- R11: An indirect branch (kind 3) is predicted taken to the buffer target on a hit (pr_src=1) and to lk_static_tgt on a miss (pr_src=2).
- R12: With lk_valid=0, and out of reset, all outputs are zero and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Branch PC |
| lk_kind | input | 3 | Branch kind code |
| lk_backward | input | 1 | Decoded target lies below the PC |
| lk_static_tgt | input | 32 | Decoded static target |
| lk_fallthru | input | 32 | Address after the branch, pushed by calls |
| upd_valid | input | 1 | Retired branch update |
| upd_pc | input | 32 | PC of the retired branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |
| pr_valid | output | 1 | A prediction is given |
| pr_taken | output | 1 | Predicted direction |
| pr_target | output | 32 | Predicted target |
| pr_src | output | 2 | 0 none, 1 buffer, 2 static, 3 stack |

## Verification
The bench walks one buffer counter through both saturation ends and back. A design that wraps the counter, or that thresholds it on the wrong bit, would flip the predicted direction after the extra updates. It checks that an allocation made by a not-taken update overrides the backward-taken rule, and that a PC which differs only in its tag misses. A design that compared too few tag bits would show a buffer hit there. On the return stack it pushes one more address than the stack holds, pops until the stack is empty, and places far transfers and an empty pop between calls. A design whose pointer or occupancy wraps wrongly would return stale addresses, or would predict on an empty stack.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    localparam int PC_W      = 32;
    localparam int IDX_W     = 4;
    localparam int TAG_W     = 8;
    localparam int RAS_DEPTH = 16;

    typedef enum logic [2:0] {
        K_COND    = 3'd0,
        K_CALL    = 3'd1,
        K_RET     = 3'd2,
        K_IND     = 3'd3,
        K_FARCALL = 3'd4,
        K_IRET    = 3'd5,
        K_SWINT   = 3'd6,
        K_RSVD    = 3'd7
    } kind_t;

    typedef enum logic [1:0] {
        S_NONE   = 2'd0,
        S_BTB    = 2'd1,
        S_STATIC = 2'd2,
        S_RAS    = 2'd3
    } src_t;

    function automatic logic is_far(input logic [2:0] k);
        return k[2];
    endfunction

    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        if (up)  return (c == 2'd3) ? c : c + 2'd1;
        else     return (c == 2'd0) ? c : c - 2'd1;
    endfunction
endpackage

// File: rtl/bpu_btb.sv
module bpu_btb
    import bpu_pkg::*;
#(
    parameter int P_W = PC_W,
    parameter int I_W = IDX_W,
    parameter int T_W = TAG_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [P_W-1:0] rd_pc,
    output logic           rd_hit,
    output logic [1:0]     rd_ctr,
    output logic [P_W-1:0] rd_tgt,
    input  logic           wr_en,
    input  logic [P_W-1:0] wr_pc,
    input  logic           wr_taken,
    input  logic [P_W-1:0] wr_tgt
);
    localparam int ENTRIES = 1 << I_W;
    localparam int IDX_LO  = 2;
    localparam int TAG_LO  = IDX_LO + I_W;

    logic           valid_q [ENTRIES];
    logic [T_W-1:0] tag_q   [ENTRIES];
    logic [P_W-1:0] tgt_q   [ENTRIES];
    logic [1:0]     ctr_q   [ENTRIES];

    logic [I_W-1:0] ri, wi;
    logic [T_W-1:0] rt, wt;
    logic           wr_hit;

    assign ri = rd_pc[IDX_LO +: I_W];
    assign rt = rd_pc[TAG_LO +: T_W];
    assign wi = wr_pc[IDX_LO +: I_W];
    assign wt = wr_pc[TAG_LO +: T_W];

    assign rd_hit = valid_q[ri] && (tag_q[ri] == rt);
    assign rd_ctr = ctr_q[ri];
    assign rd_tgt = tgt_q[ri];
    assign wr_hit = valid_q[wi] && (tag_q[wi] == wt);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                valid_q[e] <= 1'b0;
                tag_q[e]   <= '0;
                tgt_q[e]   <= '0;
                ctr_q[e]   <= 2'd0;
            end
        end else if (wr_en) begin
            valid_q[wi] <= 1'b1;
            tag_q[wi]   <= wt;
            tgt_q[wi]   <= wr_tgt;
            if (wr_hit) ctr_q[wi] <= ctr_step(ctr_q[wi], wr_taken);
            else        ctr_q[wi] <= wr_taken ? 2'd2 : 2'd1;
        end
    end
endmodule

// File: rtl/bpu_ras.sv
module bpu_ras
    import bpu_pkg::*;
#(
    parameter int P_W   = PC_W,
    parameter int DEPTH = RAS_DEPTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic [P_W-1:0] push_addr,
    input  logic           pop,
    output logic [P_W-1:0] top_addr,
    output logic           empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [P_W-1:0]   stk_q [DEPTH];
    logic [PTR_W-1:0] top_q, top_inc, top_dec;
    logic [CNT_W-1:0] cnt_q;

    assign top_inc  = (top_q == LAST) ? '0 : top_q + 1'b1;
    assign top_dec  = (top_q == '0) ? LAST : top_q - 1'b1;
    assign top_addr = stk_q[top_q];
    assign empty    = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= LAST;
            cnt_q <= '0;
            for (int e = 0; e < DEPTH; e++) stk_q[e] <= '0;
        end else if (push) begin
            stk_q[top_inc] <= push_addr;
            top_q          <= top_inc;
            if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            top_q <= top_dec;
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/bpu_select.sv
module bpu_select
    import bpu_pkg::*;
#(
    parameter int P_W = PC_W
) (
    input  logic           req,
    input  logic [2:0]     kind,
    input  logic           backward,
    input  logic [P_W-1:0] static_tgt,
    input  logic           btb_hit,
    input  logic [1:0]     btb_ctr,
    input  logic [P_W-1:0] btb_tgt,
    input  logic           ras_empty,
    input  logic [P_W-1:0] ras_top,
    output logic           valid,
    output logic           taken,
    output logic [P_W-1:0] target,
    output src_t           src,
    output logic           push,
    output logic           pop
);
    always_comb begin
        valid  = 1'b0;
        taken  = 1'b0;
        target = '0;
        src    = S_NONE;
        push   = 1'b0;
        pop    = 1'b0;
        if (req && !is_far(kind)) begin
            case (kind_t'(kind))
                K_COND: begin
                    valid = 1'b1;
                    if (btb_hit) begin
                        taken  = btb_ctr[1];
                        target = btb_tgt;
                        src    = S_BTB;
                    end else begin
                        taken  = backward;
                        target = static_tgt;
                        src    = S_STATIC;
                    end
                end
                K_CALL, K_IND: begin
                    valid  = 1'b1;
                    taken  = 1'b1;
                    target = btb_hit ? btb_tgt : static_tgt;
                    src    = btb_hit ? S_BTB : S_STATIC;
                    push   = (kind_t'(kind) == K_CALL);
                end
                K_RET: begin
                    if (!ras_empty) begin
                        valid  = 1'b1;
                        taken  = 1'b1;
                        target = ras_top;
                        src    = S_RAS;
                        pop    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/branch_pred.sv
module branch_pred
    import bpu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_valid,
    input  logic [31:0] lk_pc,
    input  logic [2:0]  lk_kind,
    input  logic        lk_backward,
    input  logic [31:0] lk_static_tgt,
    input  logic [31:0] lk_fallthru,
    input  logic        upd_valid,
    input  logic [31:0] upd_pc,
    input  logic        upd_taken,
    input  logic [31:0] upd_target,
    output logic        pr_valid,
    output logic        pr_taken,
    output logic [31:0] pr_target,
    output logic [1:0]  pr_src
);
    logic        btb_hit;
    logic [1:0]  btb_ctr;
    logic [31:0] btb_tgt;
    logic        ras_empty;
    logic [31:0] ras_top;
    logic        do_push, do_pop;
    src_t        src_w;

    bpu_btb #(.P_W(PC_W), .I_W(IDX_W), .T_W(TAG_W)) u_btb (
        .clk(clk), .rst(rst),
        .rd_pc(lk_pc), .rd_hit(btb_hit), .rd_ctr(btb_ctr), .rd_tgt(btb_tgt),
        .wr_en(upd_valid), .wr_pc(upd_pc), .wr_taken(upd_taken), .wr_tgt(upd_target)
    );

    bpu_ras #(.P_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk(clk), .rst(rst),
        .push(do_push), .push_addr(lk_fallthru), .pop(do_pop),
        .top_addr(ras_top), .empty(ras_empty)
    );

    bpu_select #(.P_W(PC_W)) u_sel (
        .req(lk_valid), .kind(lk_kind), .backward(lk_backward),
        .static_tgt(lk_static_tgt),
        .btb_hit(btb_hit), .btb_ctr(btb_ctr), .btb_tgt(btb_tgt),
        .ras_empty(ras_empty), .ras_top(ras_top),
        .valid(pr_valid), .taken(pr_taken), .target(pr_target), .src(src_w),
        .push(do_push), .pop(do_pop)
    );

    assign pr_src = src_w;
endmodule

// File: rtl/bpu_checks.sv
module bpu_checks (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [2:0]  lk_kind,
    input logic        lk_backward,
    input logic [31:0] lk_static_tgt,
    input logic        pr_valid,
    input logic        pr_taken,
    input logic [31:0] pr_target,
    input logic [1:0]  pr_src,
    input logic        ras_empty
);
    a_r1_far_unpredicted: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_kind[2]) |-> !pr_valid);

    a_r1_far_keeps_stack: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_kind[2]) |=> $stable(ras_empty));

    a_r2_static_rule: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_kind == 3'd0 && pr_src == 2'd2)
            |-> (pr_taken == lk_backward && pr_target == lk_static_tgt));

    a_r7_call_fills_stack: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_kind == 3'd1) |=> !ras_empty);

    a_r8_return_from_stack: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_kind == 3'd2 && pr_valid) |-> (pr_taken && pr_src == 2'd3));

    a_r9_empty_return: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_kind == 3'd2 && ras_empty) |-> !pr_valid);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!pr_valid && !pr_taken && pr_src == 2'd0));
endmodule

bind branch_pred bpu_checks u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_kind(lk_kind),
    .lk_backward(lk_backward), .lk_static_tgt(lk_static_tgt),
    .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_target(pr_target),
    .pr_src(pr_src), .ras_empty(ras_empty)
);

// File: tb/branch_pred_bench.sv
`timescale 1ns/1ps
module branch_pred_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, lk_backward, upd_valid, upd_taken;
    logic [31:0] lk_pc, lk_static_tgt, lk_fallthru, upd_pc, upd_target;
    logic [2:0]  lk_kind;
    logic        pr_valid, pr_taken;
    logic [31:0] pr_target;
    logic [1:0]  pr_src;

    typedef struct {
        logic        v;
        logic        t;
        logic [31:0] tgt;
        logic [1:0]  s;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_bad  = 0;
    bit   done   = 0;

    localparam logic [2:0] KC = 3'd0, KL = 3'd1, KR = 3'd2, KI = 3'd3,
                           KFC = 3'd4, KIR = 3'd5, KSW = 3'd6;
    localparam logic [1:0] SN = 2'd0, SB = 2'd1, SS = 2'd2, SR = 2'd3;

    always #5 clk = ~clk;

    branch_pred u_branch_pred (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind),
        .lk_backward(lk_backward), .lk_static_tgt(lk_static_tgt), .lk_fallthru(lk_fallthru),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
        .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_target(pr_target), .pr_src(pr_src)
    );

    task automatic look(input logic [2:0] k, input logic [31:0] pc, input logic bwd,
                        input logic [31:0] st, input logic [31:0] ft,
                        input logic ev, input logic et, input logic [31:0] etg,
                        input logic [1:0] es, input string req);
        exp_t e;
        @(negedge clk);
        lk_valid = 1'b1; lk_kind = k; lk_pc = pc; lk_backward = bwd;
        lk_static_tgt = st; lk_fallthru = ft; upd_valid = 1'b0;
        e.v = ev; e.t = et; e.tgt = etg; e.s = es; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic quiet(input string req);
        exp_t e;
        @(negedge clk);
        lk_valid = 1'b0; upd_valid = 1'b0; lk_kind = KC; lk_pc = 32'h100;
        e.v = 0; e.t = 0; e.tgt = 0; e.s = SN; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
        @(negedge clk);
        lk_valid = 1'b0; upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
    endtask

    // Monitor: pops the expected item for the lookup driven at this negedge
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (pr_valid !== e.v || pr_taken !== e.t || pr_src !== e.s ||
                (e.v && pr_target !== e.tgt)) begin
                n_bad++;
                $display("FAIL %s: got v=%0b t=%0b tgt=%h src=%0d, expected v=%0b t=%0b tgt=%h src=%0d",
                         e.req, pr_valid, pr_taken, pr_target, pr_src, e.v, e.t, e.tgt, e.s);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lk_valid = 0; upd_valid = 0; lk_kind = KC; lk_pc = 0;
        lk_backward = 0; lk_static_tgt = 0; lk_fallthru = 0;
        upd_pc = 0; upd_taken = 0; upd_target = 0;
        repeat (3) @(negedge clk);
        quiet("R12 reset");
        rst = 1'b0;
        quiet("R12 idle");

        // R2 static fallback on an empty buffer
        look(KC, 32'h100, 1, 32'h80,  0, 1, 1, 32'h80,  SS, "R2 backward");
        look(KC, 32'h104, 0, 32'h200, 0, 1, 0, 32'h200, SS, "R2 forward");
        // R3 lookups do not train the buffer
        look(KC, 32'h100, 1, 32'h80,  0, 1, 1, 32'h80,  SS, "R3 repeat");
        look(KC, 32'h100, 1, 32'h80,  0, 1, 1, 32'h80,  SS, "R3 repeat2");

        // R4 allocation
        upd(32'h104, 1, 32'h300);
        look(KC, 32'h104, 0, 32'h200, 0, 1, 1, 32'h300, SB, "R4 alloc taken");
        upd(32'h100, 0, 32'h80);
        look(KC, 32'h100, 1, 32'h80,  0, 1, 0, 32'h80,  SB, "R4 alloc not-taken");

        // R5 saturation walk on 0x104 (counter now 2)
        upd(32'h104, 0, 32'h300);
        look(KC, 32'h104, 0, 32'h200, 0, 1, 0, 32'h300, SB, "R5 ctr1");
        upd(32'h104, 0, 32'h300);
        upd(32'h104, 0, 32'h300);
        upd(32'h104, 1, 32'h300);
        look(KC, 32'h104, 0, 32'h200, 0, 1, 0, 32'h300, SB, "R5 low saturate");
        upd(32'h104, 1, 32'h300);
        look(KC, 32'h104, 0, 32'h200, 0, 1, 1, 32'h300, SB, "R5 ctr2");
        upd(32'h104, 1, 32'h300);
        upd(32'h104, 1, 32'h300);
        upd(32'h104, 0, 32'h300);
        look(KC, 32'h104, 0, 32'h200, 0, 1, 1, 32'h300, SB, "R5 high saturate");

        // R6 same index, different tag
        look(KC, 32'h144, 0, 32'h500, 0, 1, 0, 32'h500, SS, "R6 tag miss");

        // R11 indirect
        look(KI, 32'h208, 0, 32'h600, 0, 1, 1, 32'h600, SS, "R11 miss");
        upd(32'h208, 1, 32'h700);
        look(KI, 32'h208, 0, 32'h600, 0, 1, 1, 32'h700, SB, "R11 hit");

        // R9 empty stack
        look(KR, 32'h900, 0, 0, 0, 0, 0, 0, SN, "R9 empty");
        // R7 R8 R1 calls, far transfers, returns
        look(KL, 32'h300, 0, 32'h1000, 32'h304, 1, 1, 32'h1000, SS, "R7 call miss");
        look(KL, 32'h400, 0, 32'h2000, 32'h404, 1, 1, 32'h2000, SS, "R7 call2");
        look(KFC, 32'h410, 0, 32'h5000, 32'h414, 0, 0, 0, SN, "R1 far call");
        look(KIR, 32'h420, 1, 32'h10, 32'h424, 0, 0, 0, SN, "R1 iret");
        look(KSW, 32'h430, 0, 32'h20, 32'h434, 0, 0, 0, SN, "R1 swint");
        look(KR, 32'h440, 0, 0, 0, 1, 1, 32'h404, SR, "R8 pop newest");
        look(KR, 32'h450, 0, 0, 0, 1, 1, 32'h304, SR, "R8 pop older");
        look(KR, 32'h460, 0, 0, 0, 0, 0, 0, SN, "R9 drained");
        upd(32'h500, 1, 32'h3000);
        look(KL, 32'h500, 0, 32'h9990, 32'h504, 1, 1, 32'h3000, SB, "R7 call hit");
        look(KR, 32'h470, 0, 0, 0, 1, 1, 32'h504, SR, "R8 after hit call");

        // R10 overflow
        for (int i = 0; i < 17; i++)
            look(KL, 32'h800 + 32'(i*64), 0, 32'h4000, 32'h1000 + 32'(i*4),
                 1, 1, 32'h4000, SS, "R10 push");
        for (int j = 0; j < 16; j++)
            look(KR, 32'hA00, 0, 0, 0, 1, 1, 32'h1000 + 32'((16-j)*4), SR, "R10 pop");
        look(KR, 32'hA00, 0, 0, 0, 0, 0, 0, SN, "R10 empty after 16");
        quiet("R12 end idle");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule